// File: doc/BRIEF.md
# SDRAM command protocol checker

This block is a passive observer placed on the command bus of a double-data-rate SDRAM controller. On every rising clock edge it takes in the already-decoded command, the target bank, a precharge-all qualifier and the clock-enable level. From these it keeps a model of the memory: which banks hold an open row, whether a read or a write burst is still occupying the data bus, whether a refresh recovery window is running, and whether the mode register has ever been written since reset.

Every command is compared with that model. A command that breaks a protocol rule raises an error. The first error is latched as a one-hot code together with a summary flag. Both stay unchanged until a synchronous clear is applied. The block drives nothing back onto the bus. It is meant for simulation-time checking and for on-chip debug of a memory controller.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After synchronous reset, `err_code` is 0 and `err_flag` is 0. All banks are idle, the mode register counts as unprogrammed, no burst is active and no refresh window is running.
- R2: Command encodings are NOP=0, ACTIVE=1, READ=2, WRITE=3, BURST STOP=4, PRECHARGE=5, AUTO REFRESH=6, SELF REFRESH=7 and MODE SET=8.
  - A command with `cke` high is executed.
  - BURST STOP during a write burst is illegal and sets code 0x01.
  - BURST STOP during a read burst is legal and ends that burst at once.
- R3: MODE SET with `cke` high while any bank is open sets code 0x02.
  - ACTIVE opens the addressed bank.
  - PRECHARGE closes the addressed bank, or every bank when `pre_all` is 1.
- R4: SELF REFRESH with `cke` low, on an edge where `cke` was high on the edge before, is self-refresh entry. Entry while any bank is open sets code 0x04.
- R5: A READ or WRITE makes a burst active on the BURST_LEN/2 edges that follow it. `cke` falling (high on the previous edge, low now) while a burst is active sets code 0x08.
- R6: On the first edge with `cke` high after an edge with `cke` low, any command other than NOP sets code 0x10.
- R7: READ or WRITE before any MODE SET since reset sets code 0x20.
- R8: After AUTO REFRESH, a non-NOP command on any of the next TRFC-1 edges sets code 0x40. A command on the TRFC-th edge after it is legal.
- R9: Error outputs are registered and appear one edge after the offending command.
  - The first error is held, and later errors are ignored while it is held.
  - If several rules break on the same edge, the lowest set bit is kept.
  - `err_flag` is 1 exactly when `err_code` is nonzero.
- R10: `clr` high on an edge clears the held code. An error detected on that same edge is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the held error |
| cmd | input | 4 | Decoded command code |
| bank | input | BANK_W | Bank addressed by ACTIVE, READ, WRITE and PRECHARGE |
| pre_all | input | 1 | Precharge targets all banks |
| cke | input | 1 | Clock-enable level on the bus |
| err_flag | output | 1 | An error is held |
| err_code | output | 7 | One-hot code of the held error |

## Verification
Every result is due on the rising edge that samples the offending command, because the capture register is the only stage between the inputs and the outputs. The bench therefore drives each command on a falling edge and reads the outputs 1 ns after the following rising edge.

Results that depend on time are laid out by edge count from the command that opens the window:
- the burst window closes BURST_LEN/2 edges after a READ or WRITE, so the first legal `cke` fall is the following edge;
- the refresh window admits a command exactly TRFC edges after AUTO REFRESH.

The vectors probe one edge inside and one edge outside each window.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_BST  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_AREF = 4'd6,
    CMD_SREF = 4'd7,
    CMD_MRS  = 4'd8
  } cmd_e;

  localparam int ERR_W       = 7;
  localparam int E_BST_WR    = 0;
  localparam int E_MODE_BUSY = 1;
  localparam int E_SREF_BUSY = 2;
  localparam int E_PD_BURST  = 3;
  localparam int E_WAKE_CMD  = 4;
  localparam int E_NO_MODE   = 5;
  localparam int E_RFC       = 6;

endpackage

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_en,
  input  logic              pre_en,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] bank,
  output logic [NUM_BANKS-1:0] open_q,
  output logic              any_open
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        open_q[g] <= 1'b0;
      else if (act_en && bank == BANK_W'(g))
        open_q[g] <= 1'b1;
      else if (pre_en && (pre_all || bank == BANK_W'(g)))
        open_q[g] <= 1'b0;
    end
  end

  assign any_open = |open_q;

  assert_act_opens_bank_R3: assert property (@(posedge clk) disable iff (rst)
    act_en |=> open_q[$past(bank)]);

  assert_pre_all_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (pre_en && pre_all && !act_en) |=> !any_open);

endmodule

// File: rtl/sdram_burst_timer.sv
module sdram_burst_timer #(
  parameter int BURST_LEN = 8,
  parameter int TRFC      = 6,
  localparam int BCYC = BURST_LEN / 2,
  localparam int CW   = $clog2(BCYC + 1),
  localparam int RW   = $clog2(TRFC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_start,
  input  logic wr_start,
  input  logic bst,
  input  logic rfc_start,
  output logic burst_act,
  output logic burst_wr,
  output logic rfc_busy
);

  logic [CW-1:0] bcnt;
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt     <= '0;
      burst_wr <= 1'b0;
    end else if (rd_start || wr_start) begin
      bcnt     <= CW'(BCYC);
      burst_wr <= wr_start;
    end else if (bst && bcnt != '0 && !burst_wr) begin
      bcnt <= '0;
    end else if (bcnt != '0) begin
      bcnt <= bcnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rcnt <= '0;
    else if (rfc_start)
      rcnt <= RW'(TRFC - 1);
    else if (rcnt != '0)
      rcnt <= rcnt - 1'b1;
  end

  assign burst_act = (bcnt != '0);
  assign rfc_busy  = (rcnt != '0);

  assert_burst_starts_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_start || wr_start) |=> burst_act);

  assert_bst_ends_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bst && burst_act && !burst_wr && !rd_start && !wr_start) |=> !burst_act);

  assert_bst_keeps_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bst && burst_wr && bcnt > CW'(1) && !rd_start && !wr_start) |=> burst_act);

  assert_rfc_window_R8: assert property (@(posedge clk) disable iff (rst)
    (rfc_start && TRFC > 1) |=> rfc_busy);

endmodule

// File: rtl/sdram_err_capture.sv
module sdram_err_capture
  import sdram_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [ERR_W-1:0] viol,
  output logic [ERR_W-1:0] err_code,
  output logic             err_flag
);

  logic [ERR_W-1:0] pick;
  logic [ERR_W-1:0] held;
  logic [ERR_W-1:0] nxt;

  assign pick = viol & (~viol + 1'b1);
  assign held = clr ? '0 : err_code;
  assign nxt  = (held != '0) ? held : pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_code <= '0;
      err_flag <= 1'b0;
    end else begin
      err_code <= nxt;
      err_flag <= (nxt != '0);
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr) |=> $stable(err_code));

  assert_flag_match_R9: assert property (@(posedge clk) disable iff (rst)
    err_flag == (err_code != '0));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr && viol == '0) |=> (err_code == '0));

  assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
    (clr && viol != '0) |=> err_flag);

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 8,
  parameter int TRFC      = 6,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [3:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              pre_all,
  input  logic              cke,
  output logic              err_flag,
  output logic [ERR_W-1:0]  err_code
);

  logic cke_q;
  logic mode_set;
  logic live;
  logic sref_entry;
  logic any_open;
  logic burst_act, burst_wr, rfc_busy;
  logic [NUM_BANKS-1:0] open_q;
  logic [ERR_W-1:0] viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q    <= 1'b1;
      mode_set <= 1'b0;
    end else begin
      cke_q <= cke;
      if (live && cmd == CMD_MRS)
        mode_set <= 1'b1;
    end
  end

  assign live       = cke;
  assign sref_entry = (cmd == CMD_SREF) && !cke && cke_q;

  sdram_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .act_en   (live && cmd == CMD_ACT),
    .pre_en   (live && cmd == CMD_PRE),
    .pre_all  (pre_all),
    .bank     (bank),
    .open_q   (open_q),
    .any_open (any_open)
  );

  sdram_burst_timer #(.BURST_LEN(BURST_LEN), .TRFC(TRFC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (live && cmd == CMD_RD),
    .wr_start  (live && cmd == CMD_WR),
    .bst       (live && cmd == CMD_BST),
    .rfc_start (live && cmd == CMD_AREF),
    .burst_act (burst_act),
    .burst_wr  (burst_wr),
    .rfc_busy  (rfc_busy)
  );

  always_comb begin
    viol              = '0;
    viol[E_BST_WR]    = live && cmd == CMD_BST && burst_act && burst_wr;
    viol[E_MODE_BUSY] = live && cmd == CMD_MRS && any_open;
    viol[E_SREF_BUSY] = sref_entry && any_open;
    viol[E_PD_BURST]  = cke_q && !cke && burst_act;
    viol[E_WAKE_CMD]  = !cke_q && cke && cmd != CMD_NOP;
    viol[E_NO_MODE]   = live && (cmd == CMD_RD || cmd == CMD_WR) && !mode_set;
    viol[E_RFC]       = live && rfc_busy && cmd != CMD_NOP;
  end

  sdram_err_capture u_err (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .viol     (viol),
    .err_code (err_code),
    .err_flag (err_flag)
  );

  assert_mode_latched_R7: assert property (@(posedge clk) disable iff (rst)
    (live && cmd == CMD_MRS) |=> mode_set);

  assert_wake_nop_R6: assert property (@(posedge clk) disable iff (rst)
    (!cke_q && cke && cmd != CMD_NOP && !err_flag) |=> err_flag);

  assert_pd_burst_R5: assert property (@(posedge clk) disable iff (rst)
    (cke_q && !cke && burst_act && !err_flag) |=> err_flag);

  assert_sref_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (sref_entry && open_q != '0 && !err_flag) |=> err_flag);

endmodule

// File: tb/sdram_cmd_checker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_checker_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic [1:0] bank = 2'd0;
  logic       pre_all = 1'b0;
  logic       cke = 1'b1;
  logic       err_flag;
  logic [6:0] err_code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_checker #(.NUM_BANKS(4), .BURST_LEN(8), .TRFC(6)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .cmd(cmd), .bank(bank),
    .pre_all(pre_all), .cke(cke), .err_flag(err_flag), .err_code(err_code)
  );

  typedef struct packed {
    logic [3:0] c;
    logic [1:0] b;
    logic       k;
    logic       pa;
    logic       cl;
    logic [6:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd1},  // 0 R1 idle NOP
    '{4'd2, 2'd0, 1'b1, 1'b0, 1'b0, 7'h20, 4'd7},  // 1 R7 read before mode set
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}, // 2 R10 clear
    '{4'd8, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd3},  // 3 R3 mode set, all idle
    '{4'd1, 2'd1, 1'b1, 1'b0, 1'b0, 7'h00, 4'd3},  // 4 open bank 1
    '{4'd8, 2'd0, 1'b1, 1'b0, 1'b0, 7'h02, 4'd3},  // 5 R3 mode set with open bank
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}, // 6 clear
    '{4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 7'h00, 4'd3},  // 7 close bank 1
    '{4'd8, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd3},  // 8 R3 legal again
    '{4'd1, 2'd2, 1'b1, 1'b0, 1'b0, 7'h00, 4'd3},  // 9 open bank 2
    '{4'd3, 2'd2, 1'b1, 1'b0, 1'b0, 7'h00, 4'd7},  // 10 R7 write allowed now
    '{4'd4, 2'd2, 1'b1, 1'b0, 1'b0, 7'h01, 4'd2},  // 11 R2 stop in write
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}, // 12 clear
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd5},  // 13
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd5},  // 14 last burst edge
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'h00, 4'd5},  // 15 R5 cke fall right after burst
    '{4'd5, 2'd2, 1'b1, 1'b0, 1'b0, 7'h10, 4'd6},  // 16 R6 non-NOP on wake
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}, // 17 clear
    '{4'd2, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd2},  // 18 read burst
    '{4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd2},  // 19 R2 stop in read legal
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'h00, 4'd2},  // 20 R2 burst ended, cke fall ok
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd6},  // 21 R6 NOP on wake legal
    '{4'd2, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd5},  // 22 read burst
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd5},  // 23
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'h08, 4'd5},  // 24 R5 power-down in burst
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}, // 25 clear with wake NOP
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd5},  // 26
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd5},  // 27
    '{4'd1, 2'd3, 1'b1, 1'b0, 1'b0, 7'h00, 4'd4},  // 28 open bank 3
    '{4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 7'h04, 4'd4},  // 29 R4 self refresh, bank open
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h00, 4'd10}, // 30 clear while cke low
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd6},  // 31 wake NOP
    '{4'd5, 2'd0, 1'b1, 1'b1, 1'b0, 7'h00, 4'd3},  // 32 R3 precharge all
    '{4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 7'h00, 4'd4},  // 33 R4 legal self refresh
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd6},  // 34 wake NOP
    '{4'd6, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd8},  // 35 R8 auto refresh
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd8},  // 36
    '{4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 7'h40, 4'd8},  // 37 R8 command in window
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}, // 38 clear
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd8},  // 39
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd8},  // 40 last window edge
    '{4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 4'd8},  // 41 R8 TRFC-th edge legal
    '{4'd8, 2'd0, 1'b1, 1'b0, 1'b0, 7'h02, 4'd3},  // 42 mode set, bank 0 open
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h02, 4'd9},  // 43 R9 held
    '{4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 7'h02, 4'd9},  // 44 R9 later error ignored
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h02, 4'd9},  // 45 still held
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}, // 46 clear
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'h00, 4'd5},  // 47 cke fall, no burst
    '{4'd8, 2'd0, 1'b1, 1'b0, 1'b0, 7'h02, 4'd9},  // 48 R9 two rules, lowest bit
    '{4'd0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h00, 4'd10}  // 49 clear
  };

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [1:0] b, input logic k,
                       input logic pa, input logic cl);
    @(negedge clk);
    cmd = c; bank = b; cke = k; pre_all = pa; clr = cl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.1;
    check("R1 reset code", err_code, 7'h00);
    check("R1 reset flag", {6'd0, err_flag}, 7'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].c, VEC[i].b, VEC[i].k, VEC[i].pa, VEC[i].cl);
      check($sformatf("R%0d vec %0d code", VEC[i].r, i), err_code, VEC[i].e);
      check($sformatf("R9 vec %0d flag", i), {6'd0, err_flag},
            {6'd0, (VEC[i].e != 7'h00)});
    end

    // R1: reset in the middle forgets the programmed mode register
    @(negedge clk);
    rst = 1'b1; cmd = 4'd0; clr = 1'b0; cke = 1'b1; pre_all = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.1;
    check("R1 reset again code", err_code, 7'h00);
    apply(4'd2, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R1 mode forgotten", err_code, 7'h20);
    // R10: an error on the clearing edge is captured
    apply(4'd2, 2'd0, 1'b1, 1'b0, 1'b1);
    check("R10 clear with error", err_code, 7'h20);
    check("R10 flag", {6'd0, err_flag}, 7'h01);
    apply(4'd0, 2'd0, 1'b1, 1'b0, 1'b1);
    check("R10 plain clear", err_code, 7'h00);
    check("R10 flag low", {6'd0, err_flag}, 7'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule